// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers a set of external interrupt request lines, each asserted by pulling it low, and offers the most urgent pending one to the processor core. Each line passes through a synchronizer, and a falling edge on the line records one pending request for that line. Among the pending requests, the lowest-numbered line always wins. A request is offered only while the core's enable-interrupts flag is high. While the flag is low, recorded requests are kept and are offered again as soon as the flag returns.

The offer to the core uses a valid/ready pair. `irq_valid` marks that an interrupt is offered and `irq_id` carries the number of the winning line. The core's `irq_ack` acts as ready. A handshake (`irq_valid` and `irq_ack` high on the same rising edge) retires only the offered line. While the offer waits for an acknowledge, the number on `irq_id` is held, even if a higher-priority line arrives in the meantime. The newcomer is offered after the handshake.

The block also holds the core's halt flip-flop. A halt command from the core sets it. Any offered interrupt clears it, and `wake` marks the cycle in which a halted core is released. An active-low reset clears the synchronizers, all pending requests and the halt flip-flop.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A request line is active when driven low (0). While every line is held high (1), `irq_valid` stays 0.
- R2: A falling edge on line n with `int_en` at 1 makes `irq_valid` 1 with `irq_id` = n after exactly three rising clock edges (two synchronizer stages plus the edge register), and not earlier.
- R3: When several lines are pending and none is being held for an acknowledge, `irq_id` names the lowest-numbered pending line (line 0 highest priority, line LINES-1 lowest).
- R4: While `int_en` is 0, `irq_valid` is 0 and pending requests are retained. When `int_en` returns to 1, the retained winner is offered in the same cycle.
- R5: A handshake clears the pending request of the offered line only. Other pending lines remain and are offered next.
- R6: While `irq_valid` is 1 and `irq_ack` is 0, `irq_id` does not change on the next cycle if `irq_valid` is still 1.
- R7: While `rst_n` is 0, and after it is released with all lines high, `irq_valid`, `halted` and `wake` are 0 and no earlier request remains.
- R8: A `halt_cmd` pulse with no interrupt offered sets `halted` to 1 on the next edge. An offered interrupt clears `halted` on the next edge, and `halt_cmd` is overridden by it. `wake` is 1 exactly while `halted` and `irq_valid` are both 1.
- R9: A line held low yields one request only. A new request needs the line to go high and fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req_n | input | LINES | Raw request lines, active low, bit n is line n |
| int_en | input | 1 | Enable-interrupts flag from the core |
| irq_ack | input | 1 | Ready from the core; a handshake retires the offered line |
| halt_cmd | input | 1 | Core request to enter the halted state |
| irq_valid | output | 1 | An enabled interrupt is offered |
| irq_id | output | $clog2(LINES) | Number of the offered line |
| halted | output | 1 | Halt flip-flop state |
| wake | output | 1 | A halted core is being released this cycle |

## Verification
The bench builds the controller with its defaults: six lines and a two-stage synchronizer. With this build, both ends of the priority order (lines 0 and 5) can be exercised directly. The exact three-edge latency from a falling edge to the offer is observable at the ports. A behavioural model runs beside the design and follows the design's outputs each cycle. Directed phases cover simultaneous arrivals, a higher-priority arrival while an offer is stalled, a request waiting out a disabled period, held-low lines, halt and wake, and a reset taken while requests are pending.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Width of a line number for a given number of lines
  function automatic int id_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  typedef enum logic {
    CORE_RUN  = 1'b0,
    CORE_HALT = 1'b1
  } halt_state_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int LINES  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_n,
  output logic [LINES-1:0] rise
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] sh_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q   <= '0;
        last_q <= 1'b0;
      end else begin
        sh_q   <= {sh_q[STAGES-2:0], ~req_n[g]};
        last_q <= sh_q[STAGES-1];
      end
    end

    // one-cycle pulse on the first synchronized cycle of an active request
    assign rise[g] = sh_q[STAGES-1] & ~last_q;
  end

endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int LINES = 6,
  parameter int IDW   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] set,
  input  logic             clr_en,
  input  logic [IDW-1:0]   clr_id,
  output logic [LINES-1:0] pend
);

  logic [LINES-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (clr_en) clr_mask = LINES'(1) << clr_id;
  end

  // a fresh edge outranks the clear of the same line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_mask) | set;
  end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int LINES = 6,
  parameter int IDW   = 3
) (
  input  logic [LINES-1:0] pend,
  output logic             any,
  output logic [IDW-1:0]   win
);

  always_comb begin
    any = |pend;
    win = '0;
    // scan downward so the lowest set index is the last written
    for (int k = LINES - 1; k >= 0; k--) begin
      if (pend[k]) win = IDW'(k);
    end
  end

endmodule

// File: rtl/irq_halt_ff.sv
module irq_halt_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_cmd,
  input  logic release_req,
  output logic halted
);

  irq_pkg::halt_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           st_q <= irq_pkg::CORE_RUN;
    else if (release_req) st_q <= irq_pkg::CORE_RUN;
    else if (halt_cmd)    st_q <= irq_pkg::CORE_HALT;
  end

  assign halted = (st_q == irq_pkg::CORE_HALT);

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int  LINES  = 6,
  parameter int  STAGES = 2,
  localparam int IDW    = irq_pkg::id_width(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_req_n,
  input  logic             int_en,
  input  logic             irq_ack,
  input  logic             halt_cmd,
  output logic             irq_valid,
  output logic [IDW-1:0]   irq_id,
  output logic             halted,
  output logic             wake
);

  logic [LINES-1:0] rise_w;
  logic [LINES-1:0] pend_q;
  logic             any_w;
  logic [IDW-1:0]   win_w;
  logic             held_q;
  logic [IDW-1:0]   held_id_q;
  logic             take_w;

  irq_sync #(.LINES(LINES), .STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .req_n (irq_req_n),
    .rise  (rise_w)
  );

  irq_pend_reg #(.LINES(LINES), .IDW(IDW)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (rise_w),
    .clr_en (take_w),
    .clr_id (irq_id),
    .pend   (pend_q)
  );

  irq_prio_enc #(.LINES(LINES), .IDW(IDW)) u_enc (
    .pend (pend_q),
    .any  (any_w),
    .win  (win_w)
  );

  assign irq_valid = int_en & any_w;
  assign irq_id    = held_q ? held_id_q : win_w;
  assign take_w    = irq_valid & irq_ack;

  // freeze the offered number while the core applies back-pressure
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q    <= 1'b0;
      held_id_q <= '0;
    end else begin
      held_q    <= irq_valid & ~irq_ack;
      held_id_q <= irq_id;
    end
  end

  irq_halt_ff u_halt (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_cmd    (halt_cmd),
    .release_req (irq_valid),
    .halted      (halted)
  );

  assign wake = halted & irq_valid;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int LINES = 6,
  parameter int IDW   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_valid,
  input logic [IDW-1:0]   irq_id,
  input logic             irq_ack,
  input logic             halt_cmd,
  input logic             halted,
  input logic [LINES-1:0] pend,
  input logic [LINES-1:0] rise
);

  // R6
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ack) |=> (!irq_valid || $stable(irq_id)));

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ack && !rise[irq_id]) |=> !pend[$past(irq_id)]);

  // R4
  keep_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid && (|pend)) |=> (|pend));

  // R8
  halt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_cmd && !irq_valid) |=> halted);

  // R8
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !halted);

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.LINES(LINES), .IDW(IDW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_valid (irq_valid),
  .irq_id    (irq_id),
  .irq_ack   (irq_ack),
  .halt_cmd  (halt_cmd),
  .halted    (halted),
  .pend      (pend_q),
  .rise      (rise_w)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;

  localparam int L = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [L-1:0] req_n = '1;
  logic         int_en = 1'b0;
  logic         irq_ack = 1'b0;
  logic         halt_cmd = 1'b0;
  logic         irq_valid;
  logic [2:0]   irq_id;
  logic         halted;
  logic         wake;

  int checks = 0;
  int errors = 0;
  string phase = "R7";
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req_n (req_n),
    .int_en    (int_en),
    .irq_ack   (irq_ack),
    .halt_cmd  (halt_cmd),
    .irq_valid (irq_valid),
    .irq_id    (irq_id),
    .halted    (halted),
    .wake      (wake)
  );

  // ---------------- behavioural reference ----------------
  int m_hist[$];      // active-high request samples, newest at back
  int m_seen;         // last sample already turned into requests
  int m_pend;
  bit m_held;
  int m_hid;
  bit m_halt;

  function automatic int first_set(input int v);
    for (int k = 0; k < L; k++) if (v[k]) return k;
    return 0;
  endfunction

  function automatic bit mv();
    return int_en && (m_pend != 0);
  endfunction

  function automatic int mid();
    return m_held ? m_hid : first_set(m_pend);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hist = '{0, 0};
      m_seen = 0;
      m_pend = 0;
      m_held = 0;
      m_hid  = 0;
      m_halt = 0;
    end else begin
      bit v;
      int id;
      int edges;
      v  = mv();
      id = mid();
      edges = m_hist[0] & ~m_seen;
      m_seen = m_hist[0];
      if (v && irq_ack) m_pend = m_pend & ~(1 << id);
      m_pend = m_pend | edges;
      m_held = v && !irq_ack;
      m_hid  = id;
      m_halt = v ? 1'b0 : (m_halt | halt_cmd);
      void'(m_hist.pop_front());
      m_hist.push_back(int'(~req_n) & ((1 << L) - 1));
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(phase, irq_valid, mv(), "model valid");
      if (mv()) chk(phase, irq_id, mid(), "model id");
      chk(phase, halted, m_halt, "model halted");
      chk(phase, wake, m_halt && mv(), "model wake");
    end
  end

  task automatic nx(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_once();
    irq_ack = 1'b1;
    nx();
    irq_ack = 1'b0;
  endtask

  initial begin
    // R7 reset state
    nx(2);
    chk("R7", irq_valid, 0, "valid in reset");
    chk("R7", halted, 0, "halted in reset");
    chk("R7", wake, 0, "wake in reset");
    rst_n = 1'b1;
    int_en = 1'b1;

    // R1 idle lines
    phase = "R1";
    nx(6);
    chk("R1", irq_valid, 0, "all lines high");

    // R2 latency
    phase = "R2";
    req_n[4] = 1'b0;
    nx();
    chk("R2", irq_valid, 0, "after 1 edge");
    nx();
    chk("R2", irq_valid, 0, "after 2 edges");
    nx();
    chk("R2", irq_valid, 1, "after 3 edges");
    chk("R2", irq_id, 4, "id line 4");
    req_n[4] = 1'b1;
    ack_once();
    chk("R5", irq_valid, 0, "retired single");

    // R3 simultaneous arrivals, R5 partial clear
    phase = "R3";
    req_n[2] = 1'b0;
    req_n[5] = 1'b0;
    nx(3);
    chk("R3", irq_id, 2, "lower number wins");
    req_n = '1;
    phase = "R5";
    ack_once();
    chk("R5", irq_valid, 1, "other kept");
    chk("R5", irq_id, 5, "next line");
    ack_once();
    chk("R5", irq_valid, 0, "all retired");

    // R6 back-pressure
    phase = "R6";
    req_n[5] = 1'b0;
    nx(3);
    chk("R6", irq_id, 5, "offer line 5");
    req_n[1] = 1'b0;
    nx(4);
    chk("R6", irq_id, 5, "held during stall");
    req_n = '1;
    ack_once();
    chk("R3", irq_id, 1, "newcomer after handshake");
    ack_once();
    chk("R6", irq_valid, 0, "drained");

    // R4 disabled period
    phase = "R4";
    int_en = 1'b0;
    req_n[0] = 1'b0;
    nx(5);
    chk("R4", irq_valid, 0, "gated");
    req_n[0] = 1'b1;
    int_en = 1'b1;
    nx();
    chk("R4", irq_valid, 1, "offered on enable");
    chk("R4", irq_id, 0, "retained line 0");
    ack_once();

    // R9 held-low line
    phase = "R9";
    req_n[3] = 1'b0;
    nx(3);
    chk("R9", irq_id, 3, "line 3 offered");
    ack_once();
    nx(5);
    chk("R9", irq_valid, 0, "no repeat while low");
    req_n[3] = 1'b1;
    nx(2);
    req_n[3] = 1'b0;
    nx(3);
    chk("R9", irq_valid, 1, "new fall");
    req_n[3] = 1'b1;
    ack_once();

    // R8 halt and wake
    phase = "R8";
    halt_cmd = 1'b1;
    nx();
    halt_cmd = 1'b0;
    chk("R8", halted, 1, "halt set");
    chk("R8", wake, 0, "no wake idle");
    nx(3);
    chk("R8", halted, 1, "halt kept");
    req_n[2] = 1'b0;
    nx(3);
    chk("R8", wake, 1, "wake pulse");
    nx();
    chk("R8", halted, 0, "released");
    chk("R8", wake, 0, "wake ended");
    halt_cmd = 1'b1;
    nx();
    halt_cmd = 1'b0;
    chk("R8", halted, 0, "halt overridden");
    req_n[2] = 1'b1;
    ack_once();

    // R7 reset with requests pending
    phase = "R7";
    req_n[0] = 1'b0;
    req_n[1] = 1'b0;
    nx(3);
    chk("R7", irq_valid, 1, "pending before reset");
    rst_n = 1'b0;
    req_n = '1;
    nx();
    chk("R7", irq_valid, 0, "valid cleared");
    rst_n = 1'b1;
    nx(5);
    chk("R7", irq_valid, 0, "no stale request");
    chk("R7", halted, 0, "halt clear");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog %s expired actual=1 expected=0", phase);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule